// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address stream for a four-beat burst to a synchronous burst SRAM. The requester gives it a start address, an ordering mode, a direction and two latency values, and pulses a request while the block is idle. After that, the block generates every beat address itself. The requester does not drive any further addresses. Each beat address stays inside the aligned four-word window that holds the start address.

The beats are paced with an x-y-y-y pattern. The first beat arrives a programmable number of cycles after the request is taken. Each later beat follows a second programmable number of cycles after the beat before it. The block offers two orderings:
- Linear: counts up from the start offset and wraps at the end of the window.
- Interleaved: XORs the start offset with a bit-reversed beat counter. A burst that starts at offset 0 therefore visits the even offsets first and then the odd ones.

When a burst runs in the opposite direction to the burst before it, the block adds one dead cycle before timing starts. A zero-turnaround input removes that dead cycle.

Top module: `burst_addr_seq`

## Requirements
- R1: While rst_ni is low and in the first cycle after it is released, busy_o, beat_o and last_o are 0.
- R2: A request (req_i high) is taken only in a cycle where busy_o is 0. While busy_o is 1, req_i, start_addr_i, interleave_i and write_i have no effect on the beats of the running burst. Once the last beat has occurred, no new burst starts unless req_i is high during an idle cycle.
- R3: With interleave_i=0 captured, beat k (k=0..3) has address {start[ADDR_W-1:2], (start[1:0]+k) mod 4}.
- R4: With interleave_i=1 captured, beat k has address {start[ADDR_W-1:2], start[1:0] XOR {k[0],k[1]}}. The XOR term is therefore 0, 2, 1, 3 for k = 0 to 3.
- R5: When no turnaround is due (first burst after reset, same direction as the previous burst, or zero-turnaround), beat_o first rises in cycle F after the accepting edge, where F = first_lat_i. Cycle 1 is the cycle right after that edge.
- R6: Beats 1 to 3 each come exactly N cycles after the previous beat, where N = next_lat_i. beat_o is 0 in the cycles between beats.
- R7: last_o is high only together with the fourth beat_o pulse. busy_o is 0 in the cycle after that pulse.
- R8: When write_i differs from the direction of the previous accepted burst and zbt_i=0, the first beat comes one cycle later (cycle F+1), and all later beats shift by the same cycle.
- R9: With zbt_i=1, a change of direction adds no cycle (R5 timing applies).
- R10: first_lat_i and next_lat_i are captured at acceptance, so changing them during a burst does not alter its timing. A latency value of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Burst request, taken when idle |
| write_i | input | 1 | Burst direction, 1 = write |
| start_addr_i | input | ADDR_W | Start word address |
| interleave_i | input | 1 | 0 = linear order, 1 = interleaved order |
| zbt_i | input | 1 | 1 = no dead cycle on direction change |
| first_lat_i | input | LAT_W | Cycles to the first beat |
| next_lat_i | input | LAT_W | Cycles between later beats |
| busy_o | output | 1 | Burst in progress (including turnaround) |
| beat_o | output | 1 | Beat strobe, addr_o valid |
| last_o | output | 1 | Fourth beat of the burst |
| addr_o | output | ADDR_W | Current beat address |

## Verification
The checker watches these protocol rules on every cycle:
- no beat is issued while idle;
- a taken request makes the block busy;
- last_o coincides with the fourth beat, and the block goes idle right after it;
- the upper address bits stay fixed for the whole burst.

Other behaviour can only be shown by the bench's scenarios: the exact beat order in each mode, the first-beat and later-beat cycle positions, the extra cycle on a direction change and its removal under zero-turnaround, and the fact that inputs changed during a burst are ignored.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TURN = 2'd1,
    ST_RUN  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/bseq_order.sv
module bseq_order #(
  parameter int unsigned OFS_W = 2
) (
  input  logic [OFS_W-1:0] start_ofs_i,
  input  logic [OFS_W-1:0] beat_idx_i,
  input  logic             interleave_i,
  output logic [OFS_W-1:0] ofs_o
);
  logic [OFS_W-1:0] idx_rev;

  for (genvar g = 0; g < OFS_W; g++) begin : g_rev
    assign idx_rev[g] = beat_idx_i[OFS_W-1-g];
  end

  always_comb begin
    if (interleave_i) ofs_o = start_ofs_i ^ idx_rev;
    else              ofs_o = start_ofs_i + beat_idx_i;
  end
endmodule

// File: rtl/bseq_timer.sv
module bseq_timer #(
  parameter int unsigned LAT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [LAT_W-1:0] load_val_i,
  input  logic             run_i,
  output logic             tick_o
);
  logic [LAT_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           cnt_q <= '0;
    else if (load_i)                       cnt_q <= load_val_i;
    else if (run_i && cnt_q > LAT_W'(1))   cnt_q <= cnt_q - LAT_W'(1);
  end
endmodule

// File: rtl/bseq_turn.sv
module bseq_turn (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic accept_i,
  input  logic write_i,
  input  logic zbt_i,
  output logic need_turn_o
);
  logic prev_vld_q, prev_wr_q;

  assign need_turn_o = prev_vld_q && (prev_wr_q != write_i) && !zbt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_vld_q <= 1'b0;
      prev_wr_q  <= 1'b0;
    end else if (accept_i) begin
      prev_vld_q <= 1'b1;
      prev_wr_q  <= write_i;
    end
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned OFS_W  = 2,
  parameter int unsigned LAT_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              interleave_i,
  input  logic              zbt_i,
  input  logic [LAT_W-1:0]  first_lat_i,
  input  logic [LAT_W-1:0]  next_lat_i,
  output logic              busy_o,
  output logic              beat_o,
  output logic              last_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int unsigned BEATS = 1 << OFS_W;
  localparam logic [OFS_W-1:0] LAST_IDX = OFS_W'(BEATS - 1);

  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] base_q;
  logic              il_q;
  logic [LAT_W-1:0]  fl_q, nl_q, fl_in, nl_in;
  logic [OFS_W-1:0]  idx_q, ofs;
  logic              accept, need_turn, tick, at_last;
  logic              tmr_load;
  logic [LAT_W-1:0]  tmr_val;

  assign fl_in   = (first_lat_i == '0) ? LAT_W'(1) : first_lat_i;
  assign nl_in   = (next_lat_i  == '0) ? LAT_W'(1) : next_lat_i;
  assign accept  = req_i && (state_q == ST_IDLE);
  assign at_last = (idx_q == LAST_IDX);

  bseq_turn u_turn (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .write_i    (write_i),
    .zbt_i      (zbt_i),
    .need_turn_o(need_turn)
  );

  // reload: direct start, end of turnaround, or between beats
  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = fl_in;
    if (accept && !need_turn) begin
      tmr_load = 1'b1;
      tmr_val  = fl_in;
    end else if (state_q == ST_TURN) begin
      tmr_load = 1'b1;
      tmr_val  = fl_q;
    end else if (tick && !at_last) begin
      tmr_load = 1'b1;
      tmr_val  = nl_q;
    end
  end

  bseq_timer #(.LAT_W(LAT_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tmr_load),
    .load_val_i(tmr_val),
    .run_i     (state_q == ST_RUN),
    .tick_o    (tick)
  );

  bseq_order #(.OFS_W(OFS_W)) u_order (
    .start_ofs_i (base_q[OFS_W-1:0]),
    .beat_idx_i  (idx_q),
    .interleave_i(il_q),
    .ofs_o       (ofs)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept) state_d = need_turn ? ST_TURN : ST_RUN;
      ST_TURN: state_d = ST_RUN;
      ST_RUN:  if (tick && at_last) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      base_q  <= '0;
      il_q    <= 1'b0;
      fl_q    <= LAT_W'(1);
      nl_q    <= LAT_W'(1);
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        base_q <= start_addr_i;
        il_q   <= interleave_i;
        fl_q   <= fl_in;
        nl_q   <= nl_in;
        idx_q  <= '0;
      end else if (tick && !at_last) begin
        idx_q  <= idx_q + OFS_W'(1);
      end
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign beat_o = tick;
  assign last_o = tick && at_last;
  assign addr_o = {base_q[ADDR_W-1:OFS_W], ofs};
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned OFS_W  = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              busy_o,
  input logic              beat_o,
  input logic              last_o,
  input logic [ADDR_W-1:0] addr_o
);
  localparam int unsigned BEATS = 1 << OFS_W;
  logic [OFS_W:0] nbeat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                nbeat_q <= '0;
    else if (req_i && !busy_o)  nbeat_q <= '0;
    else if (beat_o)            nbeat_q <= nbeat_q + 1'b1;
  end

  assert_idle_no_beat_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !beat_o);
  assert_accept_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy_o) |=> busy_o);
  assert_window_fixed_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(addr_o[ADDR_W-1:OFS_W]));
  assert_last_with_beat_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> beat_o);
  assert_last_is_fourth_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_o |-> (last_o == (nbeat_q == (OFS_W+1)'(BEATS - 1))));
  assert_idle_after_last_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> !busy_o);
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .req_i (req_i),
  .busy_o(busy_o),
  .beat_o(beat_o),
  .last_o(last_o),
  .addr_o(addr_o)
);

// File: tb/tb_burst_addr_seq.sv
module tb_burst_addr_seq;
  typedef struct packed {
    logic [15:0] addr;
    logic        il;
    logic        wr;
    logic        zbt;
    logic [2:0]  fl;
    logic [2:0]  nl;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{16'h1230, 1'b0, 1'b0, 1'b0, 3'd2, 3'd1},
    '{16'h1232, 1'b0, 1'b0, 1'b0, 3'd3, 3'd2},
    '{16'h00A5, 1'b0, 1'b1, 1'b0, 3'd2, 3'd1},
    '{16'h00A4, 1'b1, 1'b1, 1'b0, 3'd1, 3'd1},
    '{16'h7FFF, 1'b1, 1'b0, 1'b0, 3'd4, 3'd4},
    '{16'h0101, 1'b1, 1'b1, 1'b1, 3'd2, 3'd1},
    '{16'h0102, 1'b0, 1'b0, 1'b1, 3'd1, 3'd3},
    '{16'hFFFE, 1'b1, 1'b0, 1'b0, 3'd3, 3'd1}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, write_i = 1'b0, interleave_i = 1'b0, zbt_i = 1'b0;
  logic [15:0] start_addr_i = '0;
  logic [2:0]  first_lat_i = 3'd1, next_lat_i = 3'd1;
  logic        busy_o, beat_o, last_o;
  logic [15:0] addr_o;

  int n_chk = 0, n_fail = 0;
  bit have_prev = 0, prev_wr = 0;

  always #10ns clk_i = ~clk_i;

  burst_addr_seq dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .write_i(write_i),
    .start_addr_i(start_addr_i), .interleave_i(interleave_i), .zbt_i(zbt_i),
    .first_lat_i(first_lat_i), .next_lat_i(next_lat_i),
    .busy_o(busy_o), .beat_o(beat_o), .last_o(last_o), .addr_o(addr_o)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_addr(input vec_t v, input int k);
    logic [1:0] kk, o;
    kk = 2'(k);
    if (v.il) o = v.addr[1:0] ^ {kk[0], kk[1]};
    else      o = v.addr[1:0] + kk;
    return {v.addr[15:2], o};
  endfunction

  task automatic run_burst(input vec_t v, input bit poke);
    bit    turn, dchg;
    int    beats, exp_n, fl, nl;
    string ftag, atag;
    dchg  = have_prev && (prev_wr != v.wr);
    turn  = dchg && !v.zbt;
    ftag  = turn ? "R8" : (dchg ? "R9" : "R5");
    if (poke) ftag = "R10";
    atag  = poke ? "R2" : (v.il ? "R4" : "R3");
    have_prev = 1;
    prev_wr   = v.wr;
    fl = (v.fl == 0) ? 1 : int'(v.fl);
    nl = (v.nl == 0) ? 1 : int'(v.nl);
    @(negedge clk_i);
    chk(!busy_o, "R2", "idle before request", busy_o, 0);
    req_i = 1'b1; write_i = v.wr; start_addr_i = v.addr;
    interleave_i = v.il; zbt_i = v.zbt; first_lat_i = v.fl; next_lat_i = v.nl;
    @(negedge clk_i);
    req_i = 1'b0;
    beats = 0;
    for (int n = 1; n <= 40; n++) begin
      if (poke && n == 1) begin
        req_i = 1'b1; start_addr_i = ~v.addr; interleave_i = ~v.il;
        write_i = ~v.wr; first_lat_i = 3'd4; next_lat_i = 3'd4;
      end
      if (poke && n == 3) req_i = 1'b0;
      if (beats == 4) begin
        chk(!busy_o, "R7", "busy after last beat", busy_o, 0);
        break;
      end
      if (beat_o) begin
        exp_n = fl + (turn ? 1 : 0) + beats * nl;
        chk(n == exp_n, (beats == 0) ? ftag : (poke ? "R10" : "R6"),
            "beat cycle", n, exp_n);
        chk(addr_o == exp_addr(v, beats), atag, "beat address",
            addr_o, exp_addr(v, beats));
        chk(last_o == (beats == 3), "R7", "last flag", last_o, beats == 3);
        beats++;
      end else begin
        chk(!last_o, "R7", "last without beat", last_o, 0);
      end
      @(negedge clk_i);
    end
    chk(beats == 4, "R6", "beat count", beats, 4);
  endtask

  initial begin
    #(20ns * 150000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !beat_o && !last_o, "R1", "outputs in reset",
        {busy_o, beat_o, last_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!busy_o && !beat_o && !last_o, "R1", "outputs after release",
        {busy_o, beat_o, last_o}, 0);

    for (int i = 0; i < NV; i++) run_burst(VECS[i], 1'b0);

    // inputs disturbed mid-burst, direction change forces a turnaround
    run_burst('{16'h4443, 1'b0, 1'b1, 1'b0, 3'd1, 3'd1}, 1'b1);
    // after the disturbed burst, the block must stay idle
    @(negedge clk_i);
    chk(!busy_o && !beat_o, "R2", "no burst without idle request", busy_o, 0);
    // zero latencies read as one
    run_burst('{16'h2221, 1'b1, 1'b1, 1'b0, 3'd0, 3'd0}, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule